// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

This block sits next to the core of a small 8-bit controller. It picks one interrupt to service out of fourteen request sources and one power-fail warning input. Each source keeps a pending flag, which is set by a one-cycle event pulse. Each source also has its own enable, a two-bit priority code and a flag type: edge or level. A global enable gates all fourteen sources together. The power-fail input ignores the global enable and always sits on the top level.

The arbiter offers the winning request to the CPU with a request line, a 16-bit vector and the active level. The CPU then answers with an acknowledge pulse, and later with a return pulse. The block keeps one in-service bit per level. A new request is offered only when its level is strictly above every level already in service, which gives nesting.

The sequencing is a two-state machine. In `ST_IDLE` no request is offered. The transition *arm* moves to `ST_OFFER` when an eligible winner exists at a clock edge. In `ST_OFFER` the request line is high. The transition *take* returns to `ST_IDLE` on acknowledge. The transition *withdraw* returns to `ST_IDLE` when no source is eligible any more. The transition *hold* stays in `ST_OFFER`, and the offered vector is re-evaluated every cycle.

Top module: `prio_intc`

## Requirements
- R1: During and right after reset, `irq_req` is 0, all pending flags are 0, and no level is in service.
- R2: An `src_evt[i]` pulse sets pending flag i on the next edge. An `src_clr[i]` pulse clears it. If both arrive in the same cycle, the flag ends up set.
- R3: Source i is eligible only when its flag, `src_en[i]` and `glob_en` are all 1. The power-fail request (`pf_in` and `pf_en` both 1) does not depend on `glob_en`.
- R4: Priority codes 0, 1 and 2 select levels 0, 1 and 2, and level 2 is the highest. Code 3 behaves as level 2. Power-fail is at level 2 and beats every source at that level.
- R5: Among eligible sources on the same level, the lowest index wins.
- R6: The vector for source n is 8n+3, on 16 bits. The power-fail vector is 115.
- R7: A request is offered only if its level is strictly higher than the highest level in service.
- R8: `irq_req` rises one edge after an eligible winner exists. While it is high, the vector and level follow the current winner every cycle. It drops one edge after no source is eligible.
- R9: Acknowledge while `irq_req` is high has three effects. It marks the offered level in service and drops the request. It clears the winner's flag if `src_edge` is 1 for that source, and leaves the flag set if `src_edge` is 0. Acknowledge while `irq_req` is low has no effect.
- R10: Return clears the highest in-service bit. When return and acknowledge come in the same cycle, the return clears the highest bit that was set before the edge, and the acknowledged level is then marked in service.
- R11: An event pulse for the acknowledged source, arriving in the same cycle as its automatic clear, leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_evt | input | 14 | Per-source set pulses |
| src_clr | input | 14 | Per-source software clear pulses |
| src_en | input | 14 | Per-source enables |
| src_edge | input | 14 | 1 = flag cleared by acknowledge |
| src_prio | input | 28 | Two-bit priority code per source, source i at bits [2i+1:2i] |
| glob_en | input | 1 | Global enable for the fourteen sources |
| pf_in | input | 1 | Power-fail warning level |
| pf_en | input | 1 | Power-fail enable |
| ack | input | 1 | Acknowledge pulse from the CPU |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 16 | Vector address of the offered request |
| irq_lvl | output | 2 | Level of the offered request |
| pend_flags | output | 14 | Pending flags |

## Verification
Two pairs of events can collide in one cycle. The first pair is an acknowledge and a return, which both change the in-service stack. The second pair is a new event pulse and the automatic clear of the same flag on acknowledge. Directed steps provoke both pairs. The stack case is judged after the edge: a lower-level source must stay blocked until one more return arrives, which shows that the return removed the older level and kept the one just acknowledged. The flag case is judged on `pend_flags` and on a second offer of the same vector. A long random phase, with a behavioural reference model compared every cycle, produces many more such overlaps.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } intc_state_e;

endpackage

// File: rtl/intc_flags.sv
module intc_flags #(
    parameter int NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_pulse,
    input  logic [NUM_SRC-1:0] sw_clear,
    input  logic [NUM_SRC-1:0] ack_clear,
    output logic [NUM_SRC-1:0] flags
);

    // event pulses take precedence over either kind of clear
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set_pulse[i])
                flags[i] <= 1'b1;
            else if (sw_clear[i] || ack_clear[i])
                flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NUM_SRC = 14,
    parameter int NUM_LVL = 3,
    localparam int LVL_W  = $clog2(NUM_LVL),
    localparam int SEL_W  = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0]       flags,
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic [NUM_SRC*LVL_W-1:0] src_prio,
    input  logic                     glob_en,
    input  logic                     pf_req,
    input  logic [NUM_LVL-1:0]       in_service,
    output logic                     win_valid,
    output logic [SEL_W-1:0]         win_sel,
    output logic [LVL_W-1:0]         win_lvl
);

    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LVL - 1);

    function automatic logic [LVL_W-1:0] clamp_lvl(input logic [LVL_W-1:0] code);
        return (code > TOP_LVL) ? TOP_LVL : code;
    endfunction

    logic [LVL_W:0]   floor_lvl;
    logic [LVL_W-1:0] cand_lvl;

    always_comb begin
        // lowest level a new request must reach: one above the highest in service
        floor_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (in_service[l])
                floor_lvl = (LVL_W + 1)'(l + 1);
        end

        win_valid = 1'b0;
        win_sel   = '0;
        win_lvl   = '0;
        cand_lvl  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            cand_lvl = clamp_lvl(src_prio[i*LVL_W +: LVL_W]);
            if (flags[i] && src_en[i] && glob_en &&
                ({1'b0, cand_lvl} >= floor_lvl) &&
                (!win_valid || cand_lvl > win_lvl)) begin
                win_valid = 1'b1;
                win_sel   = SEL_W'(i);
                win_lvl   = cand_lvl;
            end
        end

        if (pf_req && ({1'b0, TOP_LVL} >= floor_lvl)) begin
            win_valid = 1'b1;
            win_sel   = SEL_W'(NUM_SRC);
            win_lvl   = TOP_LVL;
        end
    end

endmodule

// File: rtl/intc_service.sv
module intc_service #(
    parameter int NUM_LVL = 3,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [LVL_W-1:0]   push_lvl,
    input  logic               pop,
    output logic [NUM_LVL-1:0] in_service
);

    logic [NUM_LVL-1:0] after_pop;
    logic [NUM_LVL-1:0] nxt;

    always_comb begin
        after_pop = in_service;
        if (pop) begin
            for (int l = NUM_LVL - 1; l >= 0; l--) begin
                if (in_service[l] && (after_pop == in_service)) begin
                    after_pop[l] = 1'b0;
                end
            end
        end
        nxt = after_pop;
        if (push)
            nxt[push_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            in_service <= '0;
        else
            in_service <= nxt;
    end

endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
    parameter int NUM_SRC    = 14,
    parameter int NUM_LVL    = 3,
    parameter int VEC_W      = 16,
    parameter int VEC_STRIDE = 8,
    parameter int VEC_BASE   = 3,
    localparam int LVL_W     = $clog2(NUM_LVL),
    localparam int SEL_W     = $clog2(NUM_SRC + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_evt,
    input  logic [NUM_SRC-1:0]       src_clr,
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic [NUM_SRC-1:0]       src_edge,
    input  logic [NUM_SRC*LVL_W-1:0] src_prio,
    input  logic                     glob_en,
    input  logic                     pf_in,
    input  logic                     pf_en,
    input  logic                     ack,
    input  logic                     reti,
    output logic                     irq_req,
    output logic [VEC_W-1:0]         irq_vec,
    output logic [LVL_W-1:0]         irq_lvl,
    output logic [NUM_SRC-1:0]       pend_flags
);

    import intc_pkg::*;

    intc_state_e        state_q, state_d;
    logic               win_valid;
    logic [SEL_W-1:0]   win_sel, sel_q;
    logic [LVL_W-1:0]   win_lvl, lvl_q;
    logic [NUM_LVL-1:0] isr_q;
    logic [NUM_SRC-1:0] ack_clr;
    logic               ack_take;

    assign ack_take = ack && (state_q == ST_OFFER);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_ackclr
        assign ack_clr[i] = ack_take && src_edge[i] && (sel_q == SEL_W'(i));
    end

    intc_flags #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (src_evt),
        .sw_clear  (src_clr),
        .ack_clear (ack_clr),
        .flags     (pend_flags)
    );

    intc_arbiter #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_arb (
        .flags      (pend_flags),
        .src_en     (src_en),
        .src_prio   (src_prio),
        .glob_en    (glob_en),
        .pf_req     (pf_in && pf_en),
        .in_service (isr_q),
        .win_valid  (win_valid),
        .win_sel    (win_sel),
        .win_lvl    (win_lvl)
    );

    intc_service #(.NUM_LVL(NUM_LVL)) u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (ack_take),
        .push_lvl   (lvl_q),
        .pop        (reti),
        .in_service (isr_q)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = win_valid ? ST_OFFER : ST_IDLE;            // arm
            ST_OFFER: state_d = (ack || !win_valid) ? ST_IDLE : ST_OFFER;  // take / withdraw / hold
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // offered request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            lvl_q <= '0;
        end else if (win_valid) begin
            sel_q <= win_sel;
            lvl_q <= win_lvl;
        end
    end

    assign irq_req = (state_q == ST_OFFER);
    assign irq_lvl = lvl_q;
    assign irq_vec = VEC_W'(sel_q) * VEC_W'(VEC_STRIDE) + VEC_W'(VEC_BASE);

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
    parameter int NUM_SRC    = 14,
    parameter int NUM_LVL    = 3,
    parameter int VEC_W      = 16,
    parameter int VEC_STRIDE = 8,
    parameter int VEC_BASE   = 3,
    localparam int LVL_W     = $clog2(NUM_LVL)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               glob_en,
    input logic               ack,
    input logic               reti,
    input logic               irq_req,
    input logic [VEC_W-1:0]   irq_vec,
    input logic [LVL_W-1:0]   irq_lvl,
    input logic [NUM_SRC-1:0] pend_flags,
    input logic [NUM_LVL-1:0] isr
);

    localparam logic [VEC_W-1:0] PF_VEC = VEC_W'(VEC_STRIDE * NUM_SRC + VEC_BASE);

    function automatic int top_busy(input logic [NUM_LVL-1:0] v);
        int h;
        h = -1;
        for (int l = 0; l < NUM_LVL; l++)
            if (v[l]) h = l;
        return h;
    endfunction

    assert_reset_clean_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_req && isr == '0 && pend_flags == '0));

    assert_above_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (int'(irq_lvl) > top_busy(isr)));

    assert_ack_marks_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |=> (isr[$past(irq_lvl)] && !irq_req));

    assert_ack_idle_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_req && !reti) |=> $stable(isr));

    assert_reti_pops_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !(ack && irq_req) && isr != '0) |=>
            ($countones(isr) == $countones($past(isr)) - 1));

    assert_vector_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'd3));

    assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !$past(glob_en)) |-> (irq_vec == PF_VEC));

endmodule

bind prio_intc prio_intc_chk #(
    .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .VEC_W(VEC_W),
    .VEC_STRIDE(VEC_STRIDE), .VEC_BASE(VEC_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .glob_en    (glob_en),
    .ack        (ack),
    .reti       (reti),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .irq_lvl    (irq_lvl),
    .pend_flags (pend_flags),
    .isr        (isr_q)
);

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;

    localparam int NS = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_evt = '0, src_clr = '0, src_en = '0, src_edge = '0;
    logic [2*NS-1:0] src_prio = '0;
    logic          glob_en = 1'b0, pf_in = 1'b0, pf_en = 1'b0, ack = 1'b0, reti = 1'b0;
    logic          irq_req;
    logic [15:0]   irq_vec;
    logic [1:0]    irq_lvl;
    logic [NS-1:0] pend_flags;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    prio_intc i_prio_intc (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_clr(src_clr),
        .src_en(src_en), .src_edge(src_edge), .src_prio(src_prio),
        .glob_en(glob_en), .pf_in(pf_in), .pf_en(pf_en), .ack(ack), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl), .pend_flags(pend_flags)
    );

    // ---------------- behavioural reference model ----------------
    bit m_flag[NS];
    bit m_busy[3];
    bit m_req;
    int m_vec, m_lvl, m_sel;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_flag[i]) m_flag[i] = 0;
            foreach (m_busy[l]) m_busy[l] = 0;
            m_req = 0; m_vec = 3; m_lvl = 0; m_sel = 0;
        end else begin
            int hi, bl, bs, code;
            bit found, take;
            hi = -1;
            for (int l = 0; l < 3; l++) if (m_busy[l]) hi = l;
            found = 0; bl = -1; bs = 0;
            if (pf_in && pf_en && 2 > hi) begin
                found = 1; bl = 2; bs = NS;
            end else begin
                for (int i = 0; i < NS; i++) begin
                    code = int'(src_prio[2*i +: 2]);
                    if (code > 2) code = 2;
                    if (m_flag[i] && src_en[i] && glob_en && code > hi && code > bl) begin
                        found = 1; bl = code; bs = i;
                    end
                end
            end
            take = ack && m_req;
            if (reti && hi >= 0) m_busy[hi] = 0;
            if (take) m_busy[m_lvl] = 1;
            for (int i = 0; i < NS; i++) begin
                if (src_clr[i]) m_flag[i] = 0;
                if (take && m_sel == i && src_edge[i]) m_flag[i] = 0;
                if (src_evt[i]) m_flag[i] = 1;
            end
            m_req = take ? 1'b0 : found;
            if (found) begin
                m_vec = 8 * bs + 3; m_lvl = bl; m_sel = bs;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [NS-1:0] mf;
            foreach (m_flag[i]) mf[i] = m_flag[i];
            n_cmp++;
            if (irq_req !== m_req || (m_req && (irq_vec !== 16'(m_vec) || irq_lvl !== 2'(m_lvl)))) begin
                n_bad++;
                $display("FAIL R8 model: req/vec/lvl got %0b/%0d/%0d exp %0b/%0d/%0d",
                         irq_req, irq_vec, irq_lvl, m_req, m_vec, m_lvl);
            end
            n_cmp++;
            if (pend_flags !== mf) begin
                n_bad++;
                $display("FAIL R2 model: flags got %h exp %h", pend_flags, mf);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic evt(input logic [NS-1:0] m);
        src_evt = m; @(negedge clk); src_evt = '0;
    endtask

    task automatic do_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1; @(negedge clk); reti = 1'b0;
    endtask

    task automatic set_prio(input int i, input int v);
        src_prio[2*i +: 2] = 2'(v);
    endtask

    task automatic expect_out(input bit r, input int v, input int l, input string tag);
        n_cmp++;
        if (irq_req !== r || (r && (irq_vec !== 16'(v) || irq_lvl !== 2'(l)))) begin
            n_bad++;
            $display("FAIL %s: req/vec/lvl got %0b/%0d/%0d exp %0b/%0d/%0d",
                     tag, irq_req, irq_vec, irq_lvl, r, v, l);
        end
    endtask

    task automatic expect_pend(input int i, input bit v, input string tag);
        n_cmp++;
        if (pend_flags[i] !== v) begin
            n_bad++;
            $display("FAIL %s: flag %0d got %0b exp %0b", tag, i, pend_flags[i], v);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout exp completion");
        finish_run();
    end

    // ---------------- directed and random stimulus ----------------
    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: clean after reset
        expect_out(0, 0, 0, "R1");
        n_cmp++;
        if (pend_flags !== '0) begin
            n_bad++; $display("FAIL R1: flags got %h exp 0", pend_flags);
        end

        src_en = '1; src_edge = '1; glob_en = 1'b1;

        // R2 / R8 / R6: single source
        evt(NS'(1) << 5);
        expect_pend(5, 1, "R2");
        expect_out(0, 0, 0, "R8");
        cyc(1);
        expect_out(1, 43, 0, "R6");
        do_ack();
        expect_out(0, 0, 0, "R9");
        expect_pend(5, 0, "R9");
        // R7: same level blocked while level 0 in service
        evt(NS'(1) << 2);
        cyc(2);
        expect_out(0, 0, 0, "R7");
        do_reti();
        cyc(1);
        expect_out(1, 19, 0, "R10");
        do_ack(); do_reti(); cyc(1);

        // R5: tie on level 1
        set_prio(3, 1); set_prio(9, 1);
        evt((NS'(1) << 3) | (NS'(1) << 9));
        cyc(1);
        expect_out(1, 27, 1, "R5");
        do_ack(); cyc(1);
        expect_out(0, 0, 0, "R7");
        do_reti(); cyc(1);
        expect_out(1, 75, 1, "R5");
        do_ack(); do_reti(); cyc(1);

        // R4: code 3 acts as top level
        set_prio(10, 3); set_prio(1, 1);
        evt((NS'(1) << 10) | (NS'(1) << 1));
        cyc(1);
        expect_out(1, 83, 2, "R4");
        do_ack(); cyc(1);
        expect_out(0, 0, 0, "R7");
        do_reti(); cyc(1);
        expect_out(1, 11, 1, "R4");
        do_ack(); do_reti(); cyc(1);

        // R3: global enable and power-fail
        glob_en = 1'b0;
        evt(NS'(1) << 4);
        cyc(2);
        expect_out(0, 0, 0, "R3");
        pf_en = 1'b1; pf_in = 1'b1;
        cyc(1);
        expect_out(1, 115, 2, "R3");
        pf_en = 1'b0;
        cyc(1);
        expect_out(0, 0, 0, "R8");
        glob_en = 1'b1;
        cyc(1);
        expect_out(1, 35, 0, "R3");
        src_clr = NS'(1) << 4; cyc(1); src_clr = '0;
        cyc(1);
        expect_out(0, 0, 0, "R2");
        pf_in = 1'b0;

        // R9: level-type flag survives acknowledge
        src_edge[6] = 1'b0;
        evt(NS'(1) << 6);
        cyc(1);
        expect_out(1, 51, 0, "R9");
        do_ack();
        expect_pend(6, 1, "R9");
        cyc(1);
        expect_out(0, 0, 0, "R7");
        src_clr = NS'(1) << 6; cyc(1); src_clr = '0;
        do_reti(); cyc(1);
        expect_out(0, 0, 0, "R2");
        src_edge[6] = 1'b1;

        // R11: event pulse coincides with acknowledge clear
        evt(NS'(1) << 7);
        cyc(1);
        expect_out(1, 59, 0, "R11");
        ack = 1'b1; src_evt = NS'(1) << 7;
        cyc(1);
        ack = 1'b0; src_evt = '0;
        expect_pend(7, 1, "R11");
        do_reti(); cyc(1);
        expect_out(1, 59, 0, "R11");
        do_ack();
        expect_pend(7, 0, "R9");
        do_reti(); cyc(1);

        // R9: acknowledge with no request is ignored
        do_ack();
        evt(NS'(1) << 8);
        cyc(1);
        expect_out(1, 67, 0, "R9");
        do_ack(); do_reti(); cyc(1);

        // R10: return and acknowledge in one cycle
        set_prio(0, 0); set_prio(1, 2); set_prio(3, 1);
        evt(NS'(1) << 0);
        cyc(1);
        expect_out(1, 3, 0, "R10");
        do_ack();
        evt(NS'(1) << 1);
        cyc(1);
        expect_out(1, 11, 2, "R7");
        ack = 1'b1; reti = 1'b1;
        cyc(1);
        ack = 1'b0; reti = 1'b0;
        evt(NS'(1) << 3);
        cyc(2);
        expect_out(0, 0, 0, "R10");
        do_reti(); cyc(1);
        expect_out(1, 27, 1, "R10");
        do_ack(); do_reti(); cyc(1);

        // random phase, judged by the reference model every cycle
        for (int k = 0; k < 3000; k++) begin
            src_evt  = NS'($urandom & $urandom & $urandom);
            src_clr  = NS'($urandom & $urandom & $urandom & $urandom);
            ack      = ($urandom % 3) == 0;
            reti     = ($urandom % 4) == 0;
            if (($urandom % 50) == 0) glob_en = ~glob_en;
            if (($urandom % 40) == 0) pf_in = ~pf_in;
            if (($urandom % 60) == 0) pf_en = ~pf_en;
            if (($urandom % 30) == 0) src_prio = 28'($urandom);
            if (($urandom % 30) == 0) src_edge = NS'($urandom);
            if (($urandom % 45) == 0) src_en = NS'($urandom | $urandom);
            cyc(1);
        end
        src_evt = '0; src_clr = '0; ack = 1'b0; reti = 1'b0;
        cyc(2);
        finish_run();
    end

endmodule